// File: doc/BRIEF.md
# Barrel Thread Scheduler

This block chooses which hardware thread feeds the fetch stage of a barrel-style pipeline. It keeps one program counter per thread, along with a small state for each: ready, in flight, or parked. In every cycle it looks at the threads that are enabled and ready. It picks one of them in round-robin order, beginning after the thread it issued last, and presents that thread's ID and PC to fetch. At the clock edge the chosen thread goes into flight. It cannot be picked again until the pipeline reports that its one instruction has completed, so the pipeline never needs to check dependences between two instructions from the same thread.

The completion strobe carries a thread ID and the PC to fetch next. A normal completion stores that PC and returns the thread to the ready pool at the sampling edge, so the thread can be chosen in the following cycle. A completion flagged as a long-latency wait also stores the PC, but it parks the thread. A parked thread stays out of selection until a wake strobe names it. When no enabled thread is ready, the fetch-valid output drops and a bubble enters the pipeline.

Top module: `barrel_thread_sched`

## Requirements
- R1: While reset is held, every thread's PC is loaded from its slice of `reset_pc` (thread i uses bits i*PC_W upward), every thread becomes ready, and the last-issued pointer is set to NTHR-1. So the first fetch after reset, with all threads enabled, is thread 0 at its reset vector.
- R2: `fetch_vld` is high exactly when at least one thread is enabled and ready. When it is high, `fetch_pc` is the stored PC of the thread named by `fetch_tid`.
- R3: Among the eligible threads, the chosen one is the first found by searching upward from the last issued thread plus one, wrapping modulo NTHR.
- R4: A thread issued in a cycle is not eligible again until a completion naming it has been sampled. As a result, no thread is issued in two consecutive cycles.
- R5: A completion (`cmp_vld` high, `cmp_wait` low) for an in-flight thread replaces that thread's PC with `cmp_pc` and makes the thread eligible from the next cycle.
- R6: A completion with `cmp_wait` high for an in-flight thread replaces its PC and parks it. The thread is not issued until a wake strobe (`wake_vld` with `wake_tid`) naming it has been sampled.
- R7: A completion that names a thread not in flight is ignored, and the thread's PC is kept. A wake that names a thread not parked is ignored.
- R8: A thread whose `thr_en` bit is low is never issued. When no thread is eligible, `fetch_vld` is low.
- R9: With all NTHR threads enabled and every completion arriving NTHR-1 cycles after its issue, `fetch_vld` stays high in every cycle and each thread issues exactly once in every NTHR cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_en | input | NTHR | Per-thread enable for selection |
| reset_pc | input | NTHR*PC_W | Per-thread reset vectors, thread 0 in the low slice |
| cmp_vld | input | 1 | Completion strobe |
| cmp_tid | input | TID_W | Thread ID of the completing instruction |
| cmp_pc | input | PC_W | Next PC for the completing thread |
| cmp_wait | input | 1 | Completion is a long-latency wait; park the thread |
| wake_vld | input | 1 | Wake strobe for a parked thread |
| wake_tid | input | TID_W | Thread ID to wake |
| fetch_vld | output | 1 | A thread is issued to fetch this cycle |
| fetch_tid | output | TID_W | Issued thread ID (binary) |
| fetch_pc | output | PC_W | Issued thread's PC |

## Verification
The hardest state to reach is a thread that is parked while the others keep cycling. The bench also has to show that the thread stays out of rotation through many rounds, and that a stray completion does not disturb a thread that is not in flight. The bench models an eight-deep pipeline whose completions return seven cycles after issue. It marks issues of one chosen thread so that their completions come back as waits. It holds that thread parked for twenty cycles and sends a wake to a different thread that is not parked, then wakes the right one. Later it drains every thread by clearing all enables, injects a completion for a thread that is ready, and enables only that thread so its PC becomes visible at the fetch port.

// File: rtl/barrel_sched_pkg.sv
package barrel_sched_pkg;

    typedef enum logic [1:0] {
        TS_READY  = 2'd0,
        TS_BUSY   = 2'd1,
        TS_PARKED = 2'd2
    } thr_state_e;

    // Events seen by one thread context in one cycle
    typedef struct packed {
        logic issue;
        logic hit_cmp;
        logic to_park;
        logic hit_wake;
    } slot_evt_t;

    // Add an offset to an index and wrap once modulo n
    function automatic int wrap_add(input int base, input int off, input int n);
        int s;
        s = base + off;
        if (s >= n) s = s - n;
        return s;
    endfunction

endpackage

// File: rtl/thread_slot.sv
module thread_slot
    import barrel_sched_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TID_W = 3,
    parameter int MY_ID = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  rst_vec,
    input  logic             issue,
    input  logic             cmp_vld,
    input  logic [TID_W-1:0] cmp_tid,
    input  logic [PC_W-1:0]  cmp_pc,
    input  logic             cmp_wait,
    input  logic             wake_vld,
    input  logic [TID_W-1:0] wake_tid,
    output logic             slot_ready,
    output logic [PC_W-1:0]  slot_pc
);

    localparam logic [TID_W-1:0] ID = TID_W'(MY_ID);

    thr_state_e      state_q;
    logic [PC_W-1:0] pc_q;
    slot_evt_t       ev;

    always_comb begin
        ev.issue    = issue && (state_q == TS_READY);
        ev.hit_cmp  = cmp_vld && (cmp_tid == ID) && (state_q == TS_BUSY);
        ev.to_park  = ev.hit_cmp && cmp_wait;
        ev.hit_wake = wake_vld && (wake_tid == ID) && (state_q == TS_PARKED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TS_READY;
            pc_q    <= rst_vec;
        end else begin
            unique case (state_q)
                TS_READY: begin
                    if (ev.issue) state_q <= TS_BUSY;
                end
                TS_BUSY: begin
                    if (ev.hit_cmp) begin
                        pc_q    <= cmp_pc;
                        state_q <= ev.to_park ? TS_PARKED : TS_READY;
                    end
                end
                TS_PARKED: begin
                    if (ev.hit_wake) state_q <= TS_READY;
                end
                default: state_q <= TS_READY;
            endcase
        end
    end

    assign slot_ready = (state_q == TS_READY);
    assign slot_pc    = pc_q;

endmodule

// File: rtl/rr_thread_pick.sv
module rr_thread_pick
    import barrel_sched_pkg::*;
#(
    parameter int NTHR  = 8,
    parameter int TID_W = 3
) (
    input  logic [NTHR-1:0]  elig,
    input  logic [TID_W-1:0] last_tid,
    output logic             any,
    output logic [TID_W-1:0] sel_tid
);

    always_comb begin
        any     = 1'b0;
        sel_tid = '0;
        for (int off = 1; off <= NTHR; off++) begin
            int idx;
            idx = wrap_add(int'(last_tid), off, NTHR);
            if (!any && elig[idx]) begin
                any     = 1'b1;
                sel_tid = TID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/barrel_thread_sched.sv
module barrel_thread_sched
    import barrel_sched_pkg::*;
#(
    parameter int NTHR  = 8,
    parameter int PC_W  = 32,
    localparam int TID_W = $clog2(NTHR)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NTHR-1:0]      thr_en,
    input  logic [NTHR*PC_W-1:0] reset_pc,
    input  logic                 cmp_vld,
    input  logic [TID_W-1:0]     cmp_tid,
    input  logic [PC_W-1:0]      cmp_pc,
    input  logic                 cmp_wait,
    input  logic                 wake_vld,
    input  logic [TID_W-1:0]     wake_tid,
    output logic                 fetch_vld,
    output logic [TID_W-1:0]     fetch_tid,
    output logic [PC_W-1:0]      fetch_pc
);

    localparam logic [TID_W-1:0] LAST_INIT = TID_W'(NTHR - 1);

    logic [NTHR-1:0] ready_vec;
    logic [NTHR-1:0] elig;
    logic [PC_W-1:0] pc_arr [NTHR];
    logic [TID_W-1:0] last_q;
    logic             pick_any;
    logic [TID_W-1:0] pick_tid;

    for (genvar g = 0; g < NTHR; g++) begin : g_slot
        thread_slot #(
            .PC_W (PC_W),
            .TID_W(TID_W),
            .MY_ID(g)
        ) u_slot (
            .clk       (clk),
            .rst       (rst),
            .rst_vec   (reset_pc[g*PC_W +: PC_W]),
            .issue     (pick_any && (pick_tid == TID_W'(g))),
            .cmp_vld   (cmp_vld),
            .cmp_tid   (cmp_tid),
            .cmp_pc    (cmp_pc),
            .cmp_wait  (cmp_wait),
            .wake_vld  (wake_vld),
            .wake_tid  (wake_tid),
            .slot_ready(ready_vec[g]),
            .slot_pc   (pc_arr[g])
        );
    end

    assign elig = ready_vec & thr_en;

    rr_thread_pick #(
        .NTHR (NTHR),
        .TID_W(TID_W)
    ) u_pick (
        .elig    (elig),
        .last_tid(last_q),
        .any     (pick_any),
        .sel_tid (pick_tid)
    );

    always_ff @(posedge clk) begin
        if (rst)           last_q <= LAST_INIT;
        else if (pick_any) last_q <= pick_tid;
    end

    assign fetch_vld = pick_any;
    assign fetch_tid = pick_tid;
    assign fetch_pc  = pc_arr[pick_tid];

endmodule

// File: rtl/barrel_thread_sched_chk.sv
module barrel_thread_sched_chk #(
    parameter int NTHR  = 8,
    parameter int PC_W  = 32,
    parameter int TID_W = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NTHR-1:0]      thr_en,
    input logic                 cmp_vld,
    input logic [TID_W-1:0]     cmp_tid,
    input logic                 cmp_wait,
    input logic                 wake_vld,
    input logic [TID_W-1:0]     wake_tid,
    input logic                 fetch_vld,
    input logic [TID_W-1:0]     fetch_tid
);

    // Occupancy rebuilt from the port traffic alone
    logic [NTHR-1:0]  c_flight;
    logic [NTHR-1:0]  c_parked;
    logic             c_prev_v;
    logic [TID_W-1:0] c_prev_tid;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_flight   <= '0;
            c_parked   <= '0;
            c_prev_v   <= 1'b0;
            c_prev_tid <= '0;
        end else begin
            for (int i = 0; i < NTHR; i++) begin
                if (fetch_vld && fetch_tid == TID_W'(i)) c_flight[i] <= 1'b1;
                if (cmp_vld && cmp_tid == TID_W'(i) && c_flight[i]) begin
                    c_flight[i] <= 1'b0;
                    if (cmp_wait) c_parked[i] <= 1'b1;
                end
                if (wake_vld && wake_tid == TID_W'(i) && c_parked[i]) c_parked[i] <= 1'b0;
            end
            c_prev_v   <= fetch_vld;
            c_prev_tid <= fetch_tid;
        end
    end

    AST_ISSUE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        fetch_vld |-> thr_en[fetch_tid]) else $error("disabled thread issued"); // R8

    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
        fetch_vld |-> !c_flight[fetch_tid]) else $error("busy thread reissued"); // R4

    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && c_prev_v) |-> (fetch_tid != c_prev_tid)) else $error("same thread twice"); // R4

    AST_PARKED_HELD: assert property (@(posedge clk) disable iff (rst)
        fetch_vld |-> !c_parked[fetch_tid]) else $error("parked thread issued"); // R6

    AST_BUBBLE_ONLY_IF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !fetch_vld |-> ((thr_en & ~c_flight & ~c_parked) == '0)) else $error("needless bubble"); // R2

endmodule

bind barrel_thread_sched barrel_thread_sched_chk #(
    .NTHR (NTHR),
    .PC_W (PC_W),
    .TID_W(TID_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .thr_en   (thr_en),
    .cmp_vld  (cmp_vld),
    .cmp_tid  (cmp_tid),
    .cmp_wait (cmp_wait),
    .wake_vld (wake_vld),
    .wake_tid (wake_tid),
    .fetch_vld(fetch_vld),
    .fetch_tid(fetch_tid)
);

// File: tb/barrel_thread_sched_bench.sv
module barrel_thread_sched_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NT  = 8;
    localparam int PW  = 32;
    localparam int TW  = 3;
    localparam int LAT = NT - 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NT-1:0]   thr_en = '1;
    logic [NT*PW-1:0] reset_pc;
    logic            cmp_vld = 1'b0;
    logic [TW-1:0]   cmp_tid = '0;
    logic [PW-1:0]   cmp_pc = '0;
    logic            cmp_wait = 1'b0;
    logic            wake_vld = 1'b0;
    logic [TW-1:0]   wake_tid = '0;
    logic            fetch_vld;
    logic [TW-1:0]   fetch_tid;
    logic [PW-1:0]   fetch_pc;

    always #(CLK_PERIOD/2) clk = ~clk;

    barrel_thread_sched #(.NTHR(NT), .PC_W(PW)) u_barrel_thread_sched (
        .clk(clk), .rst(rst), .thr_en(thr_en), .reset_pc(reset_pc),
        .cmp_vld(cmp_vld), .cmp_tid(cmp_tid), .cmp_pc(cmp_pc), .cmp_wait(cmp_wait),
        .wake_vld(wake_vld), .wake_tid(wake_tid),
        .fetch_vld(fetch_vld), .fetch_tid(fetch_tid), .fetch_pc(fetch_pc)
    );

    // Reference model: 0 ready, 1 in flight, 2 parked
    int          m_st [NT];
    logic [31:0] m_pc [NT];
    int          m_last;
    // Pipeline delay model, indexed by cycle modulo 32
    bit          pv [32];
    int          ptid [32];
    logic [31:0] ppc [32];
    bit          ppark [32];
    logic [NT-1:0] park_mask = '0;
    int cyc = 0;
    int issue_cnt [NT];
    int bubbles = 0;
    bit prev_v = 0;
    int prev_tid = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    function automatic logic [31:0] vec(input int i);
        return 32'h1000 + 32'(i) * 32'h100;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < NT; i++) issue_cnt[i] = 0;
        bubbles = 0;
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic step(input bit do_wake, input int wtid);
        int slot;
        bit e_v;
        int e_t;
        slot = cyc % 32;
        cmp_vld  = pv[slot];
        cmp_tid  = TW'(ptid[slot]);
        cmp_pc   = ppc[slot];
        cmp_wait = ppark[slot];
        pv[slot] = 0;
        wake_vld = do_wake;
        wake_tid = TW'(wtid);
        #1;
        e_v = 0;
        e_t = 0;
        for (int off = 1; off <= NT; off++) begin
            int idx;
            idx = (m_last + off) % NT;
            if (!e_v && thr_en[idx] && m_st[idx] == 0) begin
                e_v = 1;
                e_t = idx;
            end
        end
        chk(fetch_vld == e_v, "R2/R8 fetch_vld", longint'(fetch_vld), longint'(e_v));
        if (e_v) begin
            chk(int'(fetch_tid) == e_t, "R3 fetch_tid", longint'(fetch_tid), longint'(e_t));
            chk(fetch_pc == m_pc[e_t], "R2/R5 fetch_pc", longint'(fetch_pc), longint'(m_pc[e_t]));
        end
        if (prev_v && fetch_vld)
            chk(int'(fetch_tid) != prev_tid, "R4 consecutive", longint'(fetch_tid), longint'(prev_tid));
        // model update: wake on pre-edge state, then completion, then issue
        if (do_wake && m_st[wtid] == 2) m_st[wtid] = 0;
        if (cmp_vld && m_st[cmp_tid] == 1) begin
            m_pc[cmp_tid] = cmp_pc;
            m_st[cmp_tid] = cmp_wait ? 2 : 0;
        end
        if (e_v) begin
            m_st[e_t] = 1;
            m_last = e_t;
            pv[(cyc + LAT) % 32]    = 1;
            ptid[(cyc + LAT) % 32]  = e_t;
            ppc[(cyc + LAT) % 32]   = m_pc[e_t] + 32'd4;
            ppark[(cyc + LAT) % 32] = park_mask[e_t];
        end
        if (fetch_vld) issue_cnt[fetch_tid]++;
        else bubbles++;
        prev_v = fetch_vld;
        prev_tid = int'(fetch_tid);
        cyc++;
        @(negedge clk);
        wake_vld = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < NT; i++) reset_pc[i*PW +: PW] = vec(i);
        for (int i = 0; i < NT; i++) begin
            m_st[i] = 0;
            m_pc[i] = vec(i);
        end
        for (int i = 0; i < 32; i++) pv[i] = 0;
        m_last = NT - 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: first fetch after reset
        chk(fetch_vld == 1'b1, "R1 reset valid", longint'(fetch_vld), 1);
        chk(fetch_tid == 0, "R1 reset tid", longint'(fetch_tid), 0);
        chk(fetch_pc == vec(0), "R1 reset pc", longint'(fetch_pc), longint'(vec(0)));

        // R9: full occupancy with latency NT-1
        clear_counts();
        repeat (64) step(0, 0);
        chk(bubbles == 0, "R9 no bubbles", bubbles, 0);
        for (int i = 0; i < NT; i++)
            chk(issue_cnt[i] == 8, "R9 per-thread rate", issue_cnt[i], 8);
        #1;
        // R5: thread 0 now on its ninth issue, PC advanced eight times by 4
        chk(fetch_tid == 0 && fetch_pc == 32'h1020, "R5 pc update", longint'(fetch_pc), 32'h1020);

        // R8: half the threads disabled
        thr_en = 8'h0F;
        clear_counts();
        repeat (40) step(0, 0);
        for (int i = 4; i < NT; i++)
            chk(issue_cnt[i] == 0, "R8 disabled thread", issue_cnt[i], 0);
        chk(bubbles > 0, "R8 bubbles present", bubbles, 1);

        // R6: park thread 2
        thr_en = '1;
        park_mask = 8'h04;
        repeat (10) step(0, 0);
        park_mask = '0;
        clear_counts();
        repeat (20) step(0, 0);
        chk(issue_cnt[2] == 0, "R6 parked held", issue_cnt[2], 0);
        // R7: wake for a non-parked thread changes nothing
        step(1, 5);
        clear_counts();
        repeat (6) step(0, 0);
        chk(issue_cnt[2] == 0, "R7 stray wake", issue_cnt[2], 0);
        step(1, 2);
        clear_counts();
        repeat (16) step(0, 0);
        chk(issue_cnt[2] > 0, "R6 woken thread issues", issue_cnt[2], 1);

        // R7: stray completion on a ready thread
        thr_en = '0;
        repeat (12) step(0, 0);
        chk(fetch_vld == 1'b0, "R8 all disabled", longint'(fetch_vld), 0);
        pv[cyc % 32] = 1;
        ptid[cyc % 32] = 3;
        ppc[cyc % 32] = 32'hDEAD_0000;
        ppark[cyc % 32] = 0;
        step(0, 0);
        thr_en = 8'h08;
        #1;
        chk(fetch_vld && fetch_pc == m_pc[3] && fetch_pc != 32'hDEAD_0000,
            "R7 stray completion", longint'(fetch_pc), longint'(m_pc[3]));
        repeat (20) step(0, 0);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

endmodule